// File: doc/BRIEF.md
# SPI Register Access Master

This block drives a full-duplex SPI link to a peripheral that exposes a small file of byte-wide registers. Each request from the user side names one register (a 5-bit number), chooses read or write, and for a write supplies the byte to store. The block frames a two-byte exchange with select held low from before the first bit until after the last one. It then hands back two results. The first is the byte the peripheral shifted out while the command byte was going in, which the peripheral uses to report its status. The second is the byte it shifted out during the data phase, which is the register contents on a read.

The serial clock rate is set by a parameter that gives the number of system clocks in each half period of SCLK. The user interface is a start pulse, a busy level and a one-cycle done pulse. Only one exchange can be in flight at a time.

Top module: `spi_reg_master`

## Requirements
- R1: The first byte sent is the command: register number in bits 7:3, bit 1 set to 1 for a write and 0 for a read, bits 2 and 0 always 0.
- R2: Each exchange shifts exactly 16 bits, most significant bit first (command byte then data byte), producing exactly 16 SCLK high pulses.
- R3: MOSI changes only while SCLK is low. MISO is sampled while SCLK is high. Each SCLK low and high phase lasts CLK_DIV system clocks.
- R4: `cs_n` falls in the cycle after an accepted start and stays low until after the second byte. It rises together with the done pulse.
- R5: `status` reports the byte received during the command byte, for reads and for writes alike.
- R6: For a read the second byte sent is 0x00 and `rdata` reports the byte received during it. For a write the second byte sent is `wdata`.
- R7: After reset and between exchanges, `cs_n` is 1 and `sclk`, `mosi`, `busy` and `done` are 0.
- R8: `busy` is high from the cycle after an accepted start for exactly 33*CLK_DIV cycles. `done` is a single-cycle pulse in the first cycle `busy` is low, and `status` and `rdata` are valid from then on.
- R9: A `start` seen while `busy` is high is ignored: the exchange in flight is unchanged and no second exchange follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an exchange (accepted only when idle) |
| wr | input | 1 | 1 = write, 0 = read |
| reg_num | input | ADDR_W | Register number |
| wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | DATA_W | Byte received during the command byte |
| rdata | output | DATA_W | Byte received during the data byte |
| cs_n | output | 1 | Active-low peripheral select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to peripheral |
| miso | input | 1 | Serial data from peripheral |

## Verification
The assertions check several properties on every cycle. They check that select is low whenever the block is busy, that the serial lines are quiet while idle, and that MOSI holds steady while SCLK is high. They also check that done never lasts two cycles, that it follows busy, and that each completed exchange produced exactly 16 SCLK pulses. The bench sweeps every register number in both directions against a behavioural peripheral. Only these scenarios can show that the command and data bits appear in the right order, that status and read data come back from the right byte, that the busy window has the exact length, and that a start during an exchange leaves it untouched.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_LOW  = 2'd1,
    XS_HIGH = 2'd2,
    XS_TAIL = 2'd3
  } xfer_state_t;

  localparam int unsigned WR_FLAG_POS = 1;

endpackage

// File: rtl/spi_reg_tick.sv
module spi_reg_tick #(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLK_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  a_r3_count_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

endmodule

// File: rtl/spi_reg_shift.sv
module spi_reg_shift #(
  parameter int unsigned FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] tx_word,
  input  logic               shift_en,
  input  logic               miso,
  output logic               mosi,
  output logic [FRAME_W-1:0] rx_word,
  output logic               last_bit
);
  localparam int unsigned IDX_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] tx_sr;
  logic [IDX_W-1:0]   left;

  assign mosi     = tx_sr[FRAME_W-1];
  assign last_bit = (left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr   <= '0;
      rx_word <= '0;
      left    <= '0;
    end else if (load) begin
      tx_sr   <= tx_word;
      rx_word <= '0;
      left    <= IDX_W'(FRAME_W - 1);
    end else if (shift_en) begin
      tx_sr   <= {tx_sr[FRAME_W-2:0], 1'b0};
      rx_word <= {rx_word[FRAME_W-2:0], miso};
      if (left != '0) left <= left - 1'b1;
    end
  end

  // R2: the command MSB is on the line right after a load
  a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
    load |=> (mosi == $past(tx_word[FRAME_W-1])));

endmodule

// File: rtl/spi_reg_seq.sv
module spi_reg_seq
  import spi_reg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  input  logic last_bit,
  output logic busy,
  output logic cs_n,
  output logic sclk,
  output logic done,
  output logic load,
  output logic shift_en,
  output logic finish
);
  xfer_state_t state;

  assign load     = start && (state == XS_IDLE);
  assign shift_en = tick && (state == XS_HIGH);
  assign finish   = tick && (state == XS_TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= XS_IDLE;
      busy  <= 1'b0;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        XS_IDLE: if (start) begin
          state <= XS_LOW;
          busy  <= 1'b1;
          cs_n  <= 1'b0;
        end
        XS_LOW: if (tick) begin
          sclk  <= 1'b1;
          state <= XS_HIGH;
        end
        XS_HIGH: if (tick) begin
          sclk  <= 1'b0;
          state <= last_bit ? XS_TAIL : XS_LOW;
        end
        XS_TAIL: if (tick) begin
          cs_n  <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= XS_IDLE;
        end
        default: state <= XS_IDLE;
      endcase
    end
  end

  a_r4_select_low_when_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cs_n);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> ($fell(busy) && $rose(cs_n)));

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] reg_num,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] rdata,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  localparam int unsigned FRAME_W = 2 * DATA_W;
  localparam int unsigned LOW_W   = DATA_W - ADDR_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic              tick, last_bit, load, shift_en, finish;
  logic [DATA_W-1:0] cmd_byte, data_byte;
  logic [FRAME_W-1:0] rx_word;

  // R1: register number on top, write flag at its fixed position
  always_comb begin
    cmd_byte = {reg_num, {LOW_W{1'b0}}};
    cmd_byte[WR_FLAG_POS] = wr;
  end
  // R6: reads send zeros in the data byte
  assign data_byte = wr ? wdata : '0;

  spi_reg_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .tick(tick)
  );

  spi_reg_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .tick(tick), .last_bit(last_bit),
    .busy(busy), .cs_n(cs_n), .sclk(sclk), .done(done),
    .load(load), .shift_en(shift_en), .finish(finish)
  );

  spi_reg_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load(load), .tx_word({cmd_byte, data_byte}),
    .shift_en(shift_en), .miso(miso), .mosi(mosi),
    .rx_word(rx_word), .last_bit(last_bit)
  );

  // R5/R6: result registers updated at completion and held
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      rdata  <= '0;
    end else if (finish) begin
      status <= rx_word[FRAME_W-1:DATA_W];
      rdata  <= rx_word[DATA_W-1:0];
    end
  end

  // Checker state: SCLK rising edges within the current exchange
  logic             sclk_q;
  logic [CNT_W-1:0] rises;
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      rises  <= '0;
    end else begin
      sclk_q <= sclk;
      if (load)               rises <= '0;
      else if (sclk && !sclk_q) rises <= rises + 1'b1;
    end
  end

  a_r2_sixteen_pulses: assert property (@(posedge clk) disable iff (rst)
    done |-> (rises == CNT_W'(FRAME_W)));

  a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  a_r7_mosi_low_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mosi);

endmodule

// File: tb/test_spi_reg_master.sv
module test_spi_reg_master;
  localparam int DIV = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, wr = 1'b0, miso = 1'b0;
  logic [4:0] reg_num = '0;
  logic [7:0] wdata = '0;
  logic busy, done, cs_n, sclk, mosi;
  logic [7:0] status, rdata;

  always #2 clk = ~clk;

  spi_reg_master #(.ADDR_W(5), .DATA_W(8), .CLK_DIV(DIV)) i_spi_reg_master (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .reg_num(reg_num),
    .wdata(wdata), .busy(busy), .done(done), .status(status), .rdata(rdata),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural peripheral
  logic [15:0] resp = '0, cap = '0;
  int ridx = 0, pulses = 0;
  always @(negedge cs_n) begin
    cap = '0; pulses = 0; ridx = 15; miso = resp[15];
  end
  always @(posedge sclk) begin
    cap = {cap[14:0], mosi}; pulses++;
  end
  always @(negedge sclk) begin
    if (ridx > 0) begin ridx--; miso = resp[ridx]; end
  end

  // Monitors sampled at negedge clk
  int hi_change = 0, cs_glitch = 0, cyc = 0;
  logic mosi_prev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (sclk && mosi != mosi_prev) hi_change++;
    if (busy && cs_n) cs_glitch++;
    mosi_prev = mosi;
  end

  initial begin
    wait (cyc > 150000);
    check(1'b0, "watchdog", cyc, 150000);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  // Runs one exchange; returns busy length. Optionally injects a stray start.
  task automatic run_xfer(input bit w, input int r, input logic [7:0] d,
                          input bit stray, output int blen, output bit got_done);
    int guard = 0;
    blen = 0; got_done = 0;
    @(negedge clk);
    wr = w; reg_num = 5'(r); wdata = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!got_done && guard < 1000) begin
      if (busy) blen++;
      if (done) got_done = 1;
      if (stray && blen == 20) begin
        start = 1'b1; wr = ~w; reg_num = ~5'(r); wdata = ~d;
      end else start = 1'b0;
      if (!got_done) @(negedge clk);
      guard++;
    end
    start = 1'b0;
  endtask

  initial begin
    int blen; bit gd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1 && sclk == 0 && mosi == 0, "R7 idle lines after reset",
          {cs_n, sclk, mosi}, 3'b100);
    check(busy == 0 && done == 0, "R7 busy/done after reset", {busy, done}, 0);

    for (int r = 0; r < 32; r++) begin
      for (int w = 0; w < 2; w++) begin
        logic [7:0] d, st, rd, cmd;
        d   = 8'((r * 9 + 5) ^ (w * 8'hC3));
        st  = 8'(8'hA0 ^ (r * 7 + w));
        rd  = 8'(~(r * 13 + w * 3));
        cmd = 8'(r << 3) | (w ? 8'h02 : 8'h00);
        resp = {st, rd};
        run_xfer(w[0], r, d, 1'b0, blen, gd);
        check(gd, "R8 done seen", gd, 1);
        check(cap[15:8] == cmd, "R1 command byte", cap[15:8], cmd);
        check(cap[7:0] == (w ? d : 8'h00), "R6 data byte sent", cap[7:0], w ? d : 0);
        check(status == st, "R5 status byte", status, st);
        if (!w) check(rdata == rd, "R6 read data", rdata, rd);
        check(pulses == 16, "R2 sclk pulse count", pulses, 16);
        check(blen == 33 * DIV, "R8 busy length", blen, 33 * DIV);
        @(negedge clk);
        check(!done, "R8 done one cycle", done, 0);
        check(cs_n && !sclk && !mosi && !busy, "R7 idle between exchanges",
              {cs_n, sclk, mosi, busy}, 4'b1000);
        check(status == st, "R8 status held", status, st);
      end
    end

    check(hi_change == 0, "R3 mosi change while sclk high", hi_change, 0);
    check(cs_glitch == 0, "R4 select high while busy", cs_glitch, 0);

    // R9: stray start during an exchange
    resp = 16'h3C96;
    run_xfer(1'b0, 3, 8'h55, 1'b1, blen, gd);
    check(cap == 16'h1800, "R9 frame unchanged by stray start", cap, 16'h1800);
    check(rdata == 8'h96 && status == 8'h3C, "R9 results unchanged", {status, rdata}, 16'h3C96);
    check(blen == 33 * DIV, "R9 busy length unchanged", blen, 33 * DIV);
    begin
      int extra = 0;
      repeat (8 * DIV) begin
        @(negedge clk);
        if (busy || !cs_n) extra++;
      end
      check(extra == 0, "R9 no second exchange", extra, 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule